// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block collects event pulses from a multi-channel display fetch engine and turns them into sticky status flags and a single interrupt request line. Channel 0 and the controller-wide events (last frame done, quick disable done, bus error, second-interrupt) live in a primary status word. Channels 1 to 6 have their own flags in a secondary status word, at bit positions that depend on the channel number. Software reads both words, masks events through two mask registers and clears flags by writing ones.

Each event arrives as a one-cycle pulse with a channel number, the frame identifier of the descriptor that channel is working on, and that descriptor's command word. The first unmasked event seen while the interrupt line is low latches its frame identifier into an identification register. An unmasked event that arrives while the line is already high does not overwrite the latched identifier. It raises a second-interrupt flag instead, so software can see that more than one cause is pending.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset both status words, the identification register and `irq` are all zero. The enable bit and both mask registers are also zero.
- R2: `irq` is registered. One cycle after the state changes, it equals the OR of the primary status bits 0, 1, 4, 7, 8 and 9 whose bit in the primary mask is clear, ORed with any secondary status bit whose bit in the channel mask is clear. The primary mask is written through control (`wr_sel`=2, bits 11:0). The channel mask is written with `wr_sel`=3 and keeps bits 0x3F3F3F3F.
- R3: For a channel ch from 1 to 6, start-of-frame sets secondary bit ch-1, end-of-frame sets ch+7, branch sets ch+15 and underrun sets ch+23. For channel 0 these events set primary bits 1, 8, 9 and 4. An event with channel number 7 has no effect.
- R4: Start-of-frame is flagged only when `ev_cmd` bit 22 is set, and end-of-frame only when `ev_cmd` bit 21 is set.
- R5: An event counts as unmasked when its flag's mask bit is clear. A bus error always counts as unmasked. If `irq` is low, an unmasked event copies `ev_fid` into `irq_id`. If `irq` is high, it sets primary bit 10 and leaves `irq_id` unchanged. Last-frame and quick-disable events touch neither.
- R6: A bus error sets primary bit 2 and ORs its channel number into primary bits 30:28. These bits do not drive `irq`.
- R7: A write with `wr_sel`=0 clears the primary bits among 11:0 that are set in `wr_data`. When `wr_data` bit 2 is set, the write also clears bits 30:28.
- R8: A write with `wr_sel`=1 clears only the secondary bits that are set in both `wr_data` and 0x3E3F3F. The branch flag of channel 1 (bit 16) and all underrun flags are therefore not cleared.
- R9: A control write (`wr_sel`=2) that changes the enable bit (bit 31) from 1 to 0 sets primary bit 7.
- R10: A last-frame-done pulse sets primary bit 0.
- R11: When a clearing write and a new event hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 primary clear, 1 secondary clear, 2 control, 3 channel mask |
| wr_data | input | 32 | Write data |
| ev_sof | input | 1 | Start-of-frame pulse |
| ev_eof | input | 1 | End-of-frame pulse |
| ev_bra | input | 1 | Branch pulse |
| ev_und | input | 1 | Input underrun pulse |
| ev_ber | input | 1 | Bus error pulse |
| ev_ldd | input | 1 | Last frame done pulse |
| ev_ch | input | 3 | Channel of the channel events |
| ev_fid | input | ID_W | Frame identifier of that channel |
| ev_cmd | input | 32 | Command word of that channel's descriptor |
| irq | output | 1 | Interrupt request |
| stat0 | output | 32 | Primary status |
| stat1 | output | 32 | Secondary status |
| irq_id | output | ID_W | Latched frame identifier |

## Verification
The bench builds the block with the defaults NCH=7 and ID_W=16. With these values every legal channel number can be driven, and so can the unused code 7. A 16-bit identifier makes it easy to see when a latched value is overwritten. Random events on random channels are mixed with random clears and mask writes, so the bench reaches same-cycle clear-versus-set collisions, second-interrupt cases and masked-channel cases. Directed steps cover the bits that cannot be cleared and the quick-disable edge.

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl #(
  parameter int NCH  = 7,
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_sel,
  input  logic [31:0]     wr_data,
  input  logic            ev_sof,
  input  logic            ev_eof,
  input  logic            ev_bra,
  input  logic            ev_und,
  input  logic            ev_ber,
  input  logic            ev_ldd,
  input  logic [2:0]      ev_ch,
  input  logic [ID_W-1:0] ev_fid,
  input  logic [31:0]     ev_cmd,
  output logic            irq,
  output logic [31:0]     stat0,
  output logic [31:0]     stat1,
  output logic [ID_W-1:0] irq_id
);
  localparam logic [31:0] PRIM_IRQ  = 32'h0000_0393;
  localparam logic [31:0] CMASK_OK  = 32'h3F3F_3F3F;
  localparam logic [31:0] CLR1_OK   = 32'h003E_3F3F;
  localparam logic [31:0] BERCH_FLD = 32'h7000_0000;

  logic            en_q, irq_q;
  logic [31:0]     m0_q, cmask_q, st0_q, st1_q;
  logic [ID_W-1:0] id_q;

  logic ch_ok, ch0, sof_v, eof_v, bra_v, und_v, ber_v, qd, hit, sint;
  logic [4:0]  sh;
  logic [31:0] set0, set1, clr0, clr1;
  logic unused_cmd;

  assign unused_cmd = ^{ev_cmd[31:23], ev_cmd[20:0]};
  assign ch_ok = {29'd0, ev_ch} < 32'(NCH);
  assign ch0   = ev_ch == 3'd0;
  assign sof_v = ev_sof & ev_cmd[22] & ch_ok;
  assign eof_v = ev_eof & ev_cmd[21] & ch_ok;
  assign bra_v = ev_bra & ch_ok;
  assign und_v = ev_und & ch_ok;
  assign ber_v = ev_ber & ch_ok;
  assign sh    = 5'(ev_ch) - 5'd1;

  assign set1 = ch0 ? 32'd0 :
                (32'(sof_v) << sh) | (32'(eof_v) << (sh + 5'd8)) |
                (32'(bra_v) << (sh + 5'd16)) | (32'(und_v) << (sh + 5'd24));

  assign qd = wr_en && wr_sel == 2'd2 && en_q && !wr_data[31];

  always_comb begin
    set0 = 32'd0;
    if (ch0) begin
      set0[1] = sof_v;
      set0[8] = eof_v;
      set0[9] = bra_v;
      set0[4] = und_v;
    end
    if (ber_v) set0 = set0 | 32'h4 | {1'b0, ev_ch, 28'd0};
    set0[0] = set0[0] | ev_ldd;
    set0[7] = set0[7] | qd;
  end

  assign hit  = ber_v | ((set0 & 32'h0000_0312 & ~m0_q) != 32'd0) |
                ((set1 & ~cmask_q) != 32'd0);
  assign sint = hit & irq_q;

  assign clr0 = (wr_en && wr_sel == 2'd0) ?
                ((wr_data & 32'hFFF) | (wr_data[2] ? BERCH_FLD : 32'd0)) : 32'd0;
  assign clr1 = (wr_en && wr_sel == 2'd1) ? (wr_data & CLR1_OK) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; m0_q <= '0; cmask_q <= '0;
      st0_q <= '0; st1_q <= '0; id_q <= '0; irq_q <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd2) begin
        en_q <= wr_data[31];
        m0_q <= wr_data & PRIM_IRQ;
      end
      if (wr_en && wr_sel == 2'd3) cmask_q <= wr_data & CMASK_OK;
      st0_q <= (st0_q & ~clr0) | set0 | {21'd0, sint, 10'd0};
      st1_q <= (st1_q & ~clr1) | set1;
      if (hit && !irq_q) id_q <= ev_fid;
      irq_q <= ((st0_q & PRIM_IRQ & ~m0_q) != 32'd0) ||
               ((st1_q & ~cmask_q) != 32'd0);
    end
  end

  assign irq    = irq_q;
  assign stat0  = st0_q;
  assign stat1  = st1_q;
  assign irq_id = id_q;

  // R5
  id_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_q) && rst_n && $past(rst_n) |-> $stable(id_q));
  // R5
  sint_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st0_q[10]) |-> $past(irq_q));
  // R6
  berch_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st0_q[30:28] & ~$past(st0_q[30:28])) != 3'd0) |-> $past(ev_ber));
  // R4
  sof_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st1_q[5:0] & ~$past(st1_q[5:0])) != 6'd0) |-> $past(ev_sof && ev_cmd[22]));
  // R9
  qd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st0_q[7]) |-> $past(wr_en && wr_sel == 2'd2 && !wr_data[31]));
endmodule

// File: tb/test_disp_irq_ctrl.sv
module test_disp_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0; logic [1:0] wr_sel = 0; logic [31:0] wr_data = 0;
  logic ev_sof = 0, ev_eof = 0, ev_bra = 0, ev_und = 0, ev_ber = 0, ev_ldd = 0;
  logic [2:0] ev_ch = 0; logic [ID_W-1:0] ev_fid = 0; logic [31:0] ev_cmd = 0;
  logic irq; logic [31:0] stat0, stat1; logic [ID_W-1:0] irq_id;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_ctrl #(.NCH(7), .ID_W(ID_W)) i_disp_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_bra(ev_bra), .ev_und(ev_und),
    .ev_ber(ev_ber), .ev_ldd(ev_ldd), .ev_ch(ev_ch), .ev_fid(ev_fid),
    .ev_cmd(ev_cmd), .irq(irq), .stat0(stat0), .stat1(stat1), .irq_id(irq_id));

  // reference model built from the requirements
  logic m_en, m_irq; logic [31:0] m_m0, m_cm, m_s0, m_s1; logic [ID_W-1:0] m_id;

  function automatic logic [31:0] ev_bit(input int pos, input logic v);
    return v ? (32'd1 << pos) : 32'd0;
  endfunction

  always @(posedge clk) begin
    logic [31:0] a0, a1, c0, c1; logic any; int ch;
    if (!rst_n) begin
      m_en <= 0; m_irq <= 0; m_m0 <= 0; m_cm <= 0; m_s0 <= 0; m_s1 <= 0; m_id <= 0;
    end else begin
      ch = int'(ev_ch); a0 = 0; a1 = 0; any = 0;
      if (ch < 7) begin
        if (ch == 0) begin
          a0 |= ev_bit(1, ev_sof & ev_cmd[22]) | ev_bit(8, ev_eof & ev_cmd[21]) |
                ev_bit(9, ev_bra) | ev_bit(4, ev_und);
          any = ((a0 & ~m_m0) != 0);
        end else begin
          a1 = ev_bit(ch-1, ev_sof & ev_cmd[22]) | ev_bit(ch+7, ev_eof & ev_cmd[21]) |
               ev_bit(ch+15, ev_bra) | ev_bit(ch+23, ev_und);
          any = ((a1 & ~m_cm) != 0);
        end
        if (ev_ber) begin a0 |= 32'h4 | (32'(ch) << 28); any = 1; end
      end
      if (ev_ldd) a0 |= 32'h1;
      if (wr_en && wr_sel == 2 && m_en && !wr_data[31]) a0 |= 32'h80;
      if (any && m_irq) a0 |= 32'h400;
      c0 = (wr_en && wr_sel == 0) ? ((wr_data & 32'hFFF) | (wr_data[2] ? 32'h7000_0000 : 0)) : 0;
      c1 = (wr_en && wr_sel == 1) ? (wr_data & 32'h3E3F3F) : 0;
      if (any && !m_irq) m_id <= ev_fid;
      m_s0 <= (m_s0 & ~c0) | a0;
      m_s1 <= (m_s1 & ~c1) | a1;
      m_irq <= ((m_s0 & 32'h393 & ~m_m0) != 0) || ((m_s1 & ~m_cm) != 0);
      if (wr_en && wr_sel == 2) begin m_en <= wr_data[31]; m_m0 <= wr_data & 32'h393; end
      if (wr_en && wr_sel == 3) m_cm <= wr_data & 32'h3F3F3F3F;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    ev_sof = 0; ev_eof = 0; ev_bra = 0; ev_und = 0; ev_ber = 0; ev_ldd = 0;
    ev_ch = 0; ev_fid = 0; ev_cmd = 0;
  endtask

  task automatic cyc(); @(negedge clk); idle(); endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; cyc();
  endtask

  task automatic cmp_model(input string tag);
    check({tag, " irq"}, 32'(irq), 32'(m_irq));
    check({tag, " stat0"}, stat0, m_s0);
    check({tag, " stat1"}, stat1, m_s1);
    check({tag, " id"}, 32'(irq_id), 32'(m_id));
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", 32'(irq), 0); check("R1 stat0", stat0, 0);
    check("R1 stat1", stat1, 0); check("R1 id", 32'(irq_id), 0);

    // R5 first unmasked event latches id
    ev_sof = 1; ev_ch = 0; ev_cmd = 32'h0040_0000; ev_fid = 16'h0011; cyc();
    check("R3 sof ch0", stat0, 32'h2);
    check("R5 id latch", 32'(irq_id), 32'h11);
    cyc();
    check("R2 irq one cycle later", 32'(irq), 1);
    // R5 second interrupt while high
    ev_eof = 1; ev_ch = 3; ev_cmd = 32'h0020_0000; ev_fid = 16'h0022; cyc();
    check("R3 eof ch3", stat1, 32'h400);
    check("R5 sint", stat0 & 32'h400, 32'h400);
    check("R5 id kept", 32'(irq_id), 32'h11);
    // R4 sof with enable clear
    ev_sof = 1; ev_ch = 2; ev_cmd = 32'h0020_0000; cyc();
    check("R4 sof gated", stat1, 32'h400);
    // R7 clear everything
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF); cyc();
    check("R7 stat0 cleared", stat0, 0);
    check("R8 stat1 cleared", stat1, 0);
    check("R2 irq low after clear", 32'(irq), 0);
    // R6 bus error
    ev_ber = 1; ev_ch = 5; ev_fid = 16'h0033; cyc();
    check("R6 ber flags", stat0, 32'h5000_0004);
    check("R6 ber id", 32'(irq_id), 32'h33);
    cyc();
    check("R6 ber no irq", 32'(irq), 0);
    wr(0, 32'h4);
    check("R7 ber field clear", stat0, 0);
    // R8 branch ch1 not clearable
    ev_bra = 1; ev_ch = 1; ev_fid = 16'h0044; cyc();
    check("R3 bra ch1", stat1, 32'h1_0000);
    wr(1, 32'hFFFF_FFFF);
    check("R8 bit16 kept", stat1, 32'h1_0000);
    wr(3, 32'hFFFF_FFFF); cyc(); cyc();
    check("R2 masked channel", 32'(irq), 0);
    // R9 quick disable
    wr(2, 32'h8000_0000); wr(2, 32'h0);
    check("R9 qd flag", stat0 & 32'h80, 32'h80);
    // R10 last frame
    ev_ldd = 1; cyc();
    check("R10 ldd", stat0 & 32'h1, 32'h1);
    // R11 set beats clear
    ev_und = 1; ev_ch = 0; wr_en = 1; wr_sel = 0; wr_data = 32'h10; cyc();
    check("R11 set wins", stat0 & 32'h10, 32'h10);
    // R3 channel 7 ignored
    ev_sof = 1; ev_eof = 1; ev_bra = 1; ev_und = 1; ev_ch = 7; ev_cmd = 32'h0060_0000; cyc();
    cmp_model("R3 ch7");
    check("R3 ch7 stat1", stat1, 32'h1_0000);
    ev_und = 1; ev_ch = 6; cyc();
    check("R3 und ch6", stat1 & 32'h2000_0000, 32'h2000_0000);
    wr(3, 32'h0); wr(2, 32'h0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      ev_sof = r[0] & r[1]; ev_eof = r[2] & r[3]; ev_bra = r[4] & r[5] & r[6];
      ev_und = r[7] & r[8] & r[9]; ev_ber = (r[10:13] == 0); ev_ldd = (r[14:18] == 0);
      ev_ch = r[21:19]; ev_fid = 16'($urandom); ev_cmd = $urandom;
      if (r[24:22] == 0) begin
        wr_en = 1; wr_sel = r[26:25];
        wr_data = (r[26:25] == 3) ? ($urandom & $urandom) : $urandom;
      end
      cyc();
      cmp_model("R2 R5 R7 R8 R11 rnd");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule